// File: doc/BRIEF.md
# Lockable Remap Policy Register Bank

This block holds the configuration words for a DMA address-remapping engine. It decodes a 256-byte window at the top of a 4 KB register page, from F00h to FFFh. The highest word, at FFCh, is the policy word. It carries a one-shot freeze bit, a constant mode indicator and eight control bits that steer the engine's translation caches. A set of general lockable configuration words sits at the bottom of the window, one word every four bytes from F00h upward. Every control bit is also driven out as its own registered signal, and the general words are driven out as one flat bus.

Software reaches the block through a plain synchronous port with an address, a write strobe, four byte enables, write data and registered read data. Setting the freeze bit makes the entire window read-only. Only a reset can release it. The freeze state is exported so that registers elsewhere in the window can gate their own writes on it.

Top module: `rp_policy_bank`

## Requirements
- R1: After reset the policy word at FFCh reads 4000_0000h, every general word reads 0, and lock_o, gp_q_o and every control output are 0.
- R2: Bit 31 of the policy word is the freeze bit. A write can set it but no write can clear it. Only rst clears it.
- R3: While the freeze bit is set, no write to any offset from F00h to FFCh changes any stored bit, any output or any read value.
- R4: Bit 30 of the policy word always reads 1, and writes to it have no effect.
- R5: Bits 26 down to 5 of the policy word always read 0, and writes to them have no effect.
- R6: While unfrozen, policy bits 29, 28, 27, 4, 3, 2, 1 and 0 are writable and read back. They drive, in that order, l2_cpl_cache_dis_o, l1_cpl_cache_dis_o, rsvd_fault_ign_o, l1_alloc_lru_o, l1_lru_rr_start_o, ctx_cache_dis_o, l1_iotlb_dis_o and l3_iotlb_dis_o.
- R7: A write that sets the freeze bit also stores the other writable policy bits it carries, in the same write.
- R8: Byte enable be_i[n] qualifies bits 8n+7 down to 8n. A byte whose enable is low keeps its contents. The freeze bit can only be set with be_i[3] high.
- R9: General word k (k < NUM_GP) sits at byte offset F00h + 4k and is fully read/write. Any other window word, any address with addr_i[1:0] not 0, and any address outside the window reads 0, and writes to it change nothing.
- R10: rdata_o shows the word addressed in cycle t at the clock edge that closes cycle t, one cycle of latency. It reflects all writes made at earlier edges.
- R11: lock_o rises at the edge that takes the first write setting the freeze bit, and it stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Byte address |
| we_i | input | 1 | Write strobe |
| be_i | input | 4 | Byte enables |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| lock_o | output | 1 | Window freeze state |
| l2_cpl_cache_dis_o | output | 1 | Disable level-2 completion caching |
| l1_cpl_cache_dis_o | output | 1 | Disable level-1 completion caching |
| rsvd_fault_ign_o | output | 1 | Ignore reserved-field faults in translation structures |
| l1_alloc_lru_o | output | 1 | Level-1 reallocation: 1 = LRU, 0 = round robin |
| l1_lru_rr_start_o | output | 1 | LRU search start: 1 = round-robin entry, 0 = entry 0 |
| ctx_cache_dis_o | output | 1 | Disable context cache |
| l1_iotlb_dis_o | output | 1 | Disable level-1 IOTLB |
| l3_iotlb_dis_o | output | 1 | Disable level-3 IOTLB |
| gp_q_o | output | NUM_GP*32 | General configuration words, word k at bits 32k+31:32k |

## Verification
A freeze bit that fails to stick, or a write path that ignores it, shows up on the first write after locking. The control outputs or a general word change one edge later, and a read of that word returns the changed value one cycle after that. A wrong byte-enable mask or a decode slip shows up on the very next read of the affected word, or of a word that should read zero. Such a read differs from the model by whole bytes. The fixed bits 30 and 26:5 are visible in every read of FFCh, so a corrupted constant appears on the first policy read after reset.

// File: rtl/rp_pkg.sv
package rp_pkg;
  localparam int WORD_W     = 32;
  localparam int BE_W       = WORD_W / 8;
  localparam int WIN_LSB    = 8;           // 256-byte window
  localparam int IDX_W      = WIN_LSB - 2; // word index inside window
  localparam int POL_IDX    = (1 << IDX_W) - 1;
  localparam int FREEZE_BIT = 31;

  typedef struct packed {
    logic l2_cpl_dis;
    logic l1_cpl_dis;
    logic rsvd_ign;
    logic alloc_lru;
    logic lru_rr;
    logic ctx_dis;
    logic l1_io_dis;
    logic l3_io_dis;
  } pol_fields_t;
endpackage

// File: rtl/rp_addr_dec.sv
module rp_addr_dec #(
  parameter int ADDR_W   = 12,
  parameter int WIN_BASE = 12'hF00,
  parameter int NUM_GP   = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_pol_o,
  output logic [NUM_GP-1:0] hit_gp_o,
  output logic              hit_any_o
);
  import rp_pkg::*;
  localparam int TAG_W = ADDR_W - WIN_LSB;
  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(WIN_BASE);

  logic             in_win;
  logic [IDX_W-1:0] widx;

  assign widx   = addr_i[WIN_LSB-1:2];
  assign in_win = (addr_i[ADDR_W-1:WIN_LSB] == BASE_V[ADDR_W-1:WIN_LSB])
                  && (addr_i[1:0] == 2'b00);
  assign hit_pol_o = in_win && (widx == IDX_W'(POL_IDX));

  for (genvar k = 0; k < NUM_GP; k++) begin : g_dec
    assign hit_gp_o[k] = in_win && (widx == IDX_W'(k));
  end

  assign hit_any_o = hit_pol_o || (|hit_gp_o);

  logic [TAG_W-1:0] unused_tag;
  assign unused_tag = BASE_V[TAG_W-1:0];
endmodule

// File: rtl/rp_cfg_word.sv
module rp_cfg_word #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_i,
  input  logic         lock_i,
  input  logic [W/8-1:0] be_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W/8; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst)
        q_o[8*b +: 8] <= '0;
      else if (wr_i && !lock_i && be_i[b])
        q_o[8*b +: 8] <= wdata_i[8*b +: 8];
    end
  end

  AST_WORD_FROZEN: assert property (@(posedge clk) disable iff (rst)
    lock_i |=> $stable(q_o)); // R3
  AST_BYTE_KEEP: assert property (@(posedge clk) disable iff (rst)
    (wr_i && !be_i[0]) |=> q_o[7:0] == $past(q_o[7:0])); // R8
endmodule

// File: rtl/rp_policy_word.sv
module rp_policy_word
  import rp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic              lock_o,
  output pol_fields_t       fld_o,
  output logic [WORD_W-1:0] rd_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lock_o <= 1'b0;
      fld_o  <= '0;
    end else if (wr_i && !lock_o) begin
      if (be_i[3]) begin
        if (wdata_i[FREEZE_BIT]) lock_o <= 1'b1;
        fld_o.l2_cpl_dis <= wdata_i[29];
        fld_o.l1_cpl_dis <= wdata_i[28];
        fld_o.rsvd_ign   <= wdata_i[27];
      end
      if (be_i[0]) begin
        fld_o.alloc_lru <= wdata_i[4];
        fld_o.lru_rr    <= wdata_i[3];
        fld_o.ctx_dis   <= wdata_i[2];
        fld_o.l1_io_dis <= wdata_i[1];
        fld_o.l3_io_dis <= wdata_i[0];
      end
    end
  end

  assign rd_o = {lock_o, 1'b1, fld_o.l2_cpl_dis, fld_o.l1_cpl_dis,
                 fld_o.rsvd_ign, 22'd0, fld_o.alloc_lru, fld_o.lru_rr,
                 fld_o.ctx_dis, fld_o.l1_io_dis, fld_o.l3_io_dis};

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!lock_o && fld_o == '0)); // R1
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    lock_o |=> lock_o); // R2
  AST_POL_FROZEN: assert property (@(posedge clk) disable iff (rst)
    lock_o |=> $stable(fld_o)); // R3
  AST_LOCK_WITH_FIELDS: assert property (@(posedge clk) disable iff (rst)
    (wr_i && !lock_o && be_i[3] && wdata_i[FREEZE_BIT]) |=>
      (lock_o && fld_o.l2_cpl_dis == $past(wdata_i[29])
              && fld_o.rsvd_ign == $past(wdata_i[27]))); // R7
  AST_LOCK_NEEDS_BE3: assert property (@(posedge clk) disable iff (rst)
    (!lock_o && !(wr_i && be_i[3] && wdata_i[FREEZE_BIT])) |=> !lock_o); // R8
endmodule

// File: rtl/rp_policy_bank.sv
module rp_policy_bank
  import rp_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int WIN_BASE = 12'hF00,
  parameter int NUM_GP   = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     we_i,
  input  logic [3:0]               be_i,
  input  logic [31:0]              wdata_i,
  output logic [31:0]              rdata_o,
  output logic                     lock_o,
  output logic                     l2_cpl_cache_dis_o,
  output logic                     l1_cpl_cache_dis_o,
  output logic                     rsvd_fault_ign_o,
  output logic                     l1_alloc_lru_o,
  output logic                     l1_lru_rr_start_o,
  output logic                     ctx_cache_dis_o,
  output logic                     l1_iotlb_dis_o,
  output logic                     l3_iotlb_dis_o,
  output logic [NUM_GP*32-1:0]     gp_q_o
);
  logic              hit_pol;
  logic [NUM_GP-1:0] hit_gp;
  logic              hit_any;
  logic              lock_q;
  pol_fields_t       fld;
  logic [31:0]       pol_rd;
  logic [31:0]       rd_mux;

  rp_addr_dec #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .NUM_GP(NUM_GP)) u_dec (
    .addr_i(addr_i), .hit_pol_o(hit_pol), .hit_gp_o(hit_gp), .hit_any_o(hit_any)
  );

  rp_policy_word u_pol (
    .clk(clk), .rst(rst), .wr_i(we_i && hit_pol), .be_i(be_i),
    .wdata_i(wdata_i), .lock_o(lock_q), .fld_o(fld), .rd_o(pol_rd)
  );

  for (genvar k = 0; k < NUM_GP; k++) begin : g_gp
    rp_cfg_word #(.W(32)) u_word (
      .clk(clk), .rst(rst), .wr_i(we_i && hit_gp[k]), .lock_i(lock_q),
      .be_i(be_i), .wdata_i(wdata_i), .q_o(gp_q_o[32*k +: 32])
    );
  end

  always_comb begin
    rd_mux = hit_pol ? pol_rd : 32'd0;
    for (int k = 0; k < NUM_GP; k++)
      if (hit_gp[k]) rd_mux = gp_q_o[32*k +: 32];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= rd_mux;
  end

  assign lock_o             = lock_q;
  assign l2_cpl_cache_dis_o = fld.l2_cpl_dis;
  assign l1_cpl_cache_dis_o = fld.l1_cpl_dis;
  assign rsvd_fault_ign_o   = fld.rsvd_ign;
  assign l1_alloc_lru_o     = fld.alloc_lru;
  assign l1_lru_rr_start_o  = fld.lru_rr;
  assign ctx_cache_dis_o    = fld.ctx_dis;
  assign l1_iotlb_dis_o     = fld.l1_io_dis;
  assign l3_iotlb_dis_o     = fld.l3_io_dis;

  AST_DEC_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hit_pol, hit_gp})); // R9
  AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(hit_any)) |-> rdata_o == 32'd0); // R9
  AST_POL_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(hit_pol)) |-> rdata_o[30]); // R4
  AST_POL_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(hit_pol)) |-> rdata_o[26:5] == 22'd0); // R5
  AST_LOCK_READBACK: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(hit_pol)) |-> rdata_o[31] == $past(lock_o)); // R11
endmodule

// File: tb/tb_rp_policy_bank.sv
module tb_rp_policy_bank;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int NUM_GP = 4;
  localparam logic [31:0] RW_MASK = 32'h3800_001F;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic we = 1'b0;
  logic [3:0] be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic lock, l2d, l1d, rign, alru, lrr, ctxd, l1io, l3io;
  logic [NUM_GP*32-1:0] gpq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] m_gp [NUM_GP];
  logic [31:0] m_pol;
  logic        m_lock;

  always #(CLK_PERIOD/2) clk = ~clk;

  rp_policy_bank #(.ADDR_W(ADDR_W), .WIN_BASE(12'hF00), .NUM_GP(NUM_GP)) dut (
    .clk(clk), .rst(rst), .addr_i(addr), .we_i(we), .be_i(be), .wdata_i(wdata),
    .rdata_o(rdata), .lock_o(lock), .l2_cpl_cache_dis_o(l2d),
    .l1_cpl_cache_dis_o(l1d), .rsvd_fault_ign_o(rign), .l1_alloc_lru_o(alru),
    .l1_lru_rr_start_o(lrr), .ctx_cache_dis_o(ctxd), .l1_iotlb_dis_o(l1io),
    .l3_iotlb_dis_o(l3io), .gp_q_o(gpq)
  );

  function automatic logic [31:0] bmask(input logic [3:0] b);
    return {{8{b[3]}}, {8{b[2]}}, {8{b[1]}}, {8{b[0]}}};
  endfunction

  function automatic logic [31:0] exp_read(input logic [ADDR_W-1:0] a);
    if (a[ADDR_W-1:8] != 4'hF || a[1:0] != 2'b00) return 32'd0;
    if (a[7:2] == 6'd63) return {m_lock, 1'b1, m_pol[29:0] & RW_MASK[29:0]};
    if (int'(a[7:2]) < NUM_GP) return m_gp[a[7:2]];
    return 32'd0;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < NUM_GP; k++) m_gp[k] = '0;
    m_pol = '0;
    m_lock = 1'b0;
  endtask

  task automatic model_write(input logic [ADDR_W-1:0] a, input logic [3:0] b,
                             input logic [31:0] d);
    logic [31:0] m;
    m = bmask(b);
    if (m_lock || a[ADDR_W-1:8] != 4'hF || a[1:0] != 2'b00) return;
    if (a[7:2] == 6'd63) begin
      m = m & RW_MASK;
      m_pol = (m_pol & ~m) | (d & m);
      if (b[3] && d[31]) m_lock = 1'b1;
    end else if (int'(a[7:2]) < NUM_GP) begin
      m_gp[a[7:2]] = (m_gp[a[7:2]] & ~m) | (d & m);
    end
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [3:0] b,
                          input logic [31:0] d);
    addr = a; be = b; wdata = d; we = 1'b1;
    @(posedge clk); #1;
    we = 1'b0;
    model_write(a, b, d);
  endtask

  task automatic do_read(input logic [ADDR_W-1:0] a, input string tag);
    addr = a; we = 1'b0;
    @(posedge clk); #1;
    check(tag, rdata, exp_read(a));
  endtask

  task automatic check_outs(input string tag);
    logic [31:0] act, exp;
    act = {23'd0, lock, l2d, l1d, rign, alru, lrr, ctxd, l1io, l3io};
    exp = {23'd0, m_lock, m_pol[29], m_pol[28], m_pol[27], m_pol[4:0]};
    check(tag, act, exp);
    for (int k = 0; k < NUM_GP; k++) check({tag, " gp"}, gpq[32*k +: 32], m_gp[k]);
  endtask

  function automatic logic [ADDR_W-1:0] rand_addr();
    int s;
    s = int'($urandom_range(0, 9));
    if (s < 3) return 12'hFFC;
    if (s < 7) return 12'hF00 + 12'(4 * $urandom_range(0, NUM_GP - 1));
    if (s == 7) return 12'hF00 + 12'(4 * $urandom_range(NUM_GP, 62));
    if (s == 8) return 12'hF00 + 12'($urandom_range(0, 255) | 1);
    return 12'($urandom_range(0, 12'hEFF));
  endfunction

  task automatic apply_reset();
    rst = 1'b1; we = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    model_reset();
  endtask

  initial begin
    int seed_v;
    logic [ADDR_W-1:0] a;
    logic [31:0] d;
    seed_v = int'($urandom(32'd2024));
    model_reset();
    apply_reset();

    // R1 reset state
    do_read(12'hFFC, "R1 policy reset");
    check("R1 policy const", rdata, 32'h4000_0000);
    do_read(12'hF04, "R1 gp reset");
    check_outs("R1 outputs");

    // R6 R4 R5 every writable field, ones into fixed bits
    do_write(12'hFFC, 4'b1111, 32'h7FFF_FFFF);
    do_read(12'hFFC, "R6 R4 R5 all ones");
    check("R5 reserved zero", rdata, 32'h7800_001F);
    check_outs("R6 outputs");
    do_write(12'hFFC, 4'b1111, 32'h0000_0000);
    do_read(12'hFFC, "R4 bit30 holds");

    // R8 byte enables, freeze bit without be3
    do_write(12'hFFC, 4'b0001, 32'hFFFF_FFFF);
    do_read(12'hFFC, "R8 low byte only");
    check("R8 no lock w/o be3", {31'd0, lock}, 32'd0);
    do_write(12'hF08, 4'b0101, 32'hAABB_CCDD);
    do_read(12'hF08, "R8 gp partial");

    // R9 misaligned and outside window
    do_write(12'hF01, 4'b1111, 32'h1234_5678);
    do_read(12'hF00, "R9 misaligned write");
    do_read(12'hF01, "R9 misaligned read");
    do_write(12'hE00, 4'b1111, 32'hFFFF_FFFF);
    do_read(12'hE00, "R9 outside window");
    do_write(12'hF80, 4'b1111, 32'hFFFF_FFFF);
    do_read(12'hF80, "R9 unmapped");

    // R10 random unlocked traffic with freeze bit held clear
    for (int i = 0; i < 300; i++) begin
      a = rand_addr();
      d = $urandom();
      if ($urandom_range(0, 1) == 1) begin
        d[31] = 1'b0;
        do_write(a, 4'($urandom_range(0, 15)), d);
      end
      do_read(rand_addr(), "R10 R6 R9 random read");
    end
    check_outs("R6 after random");

    // R7 R11 lock write carries fields
    do_write(12'hFFC, 4'b1001, 32'hA800_0015);
    check("R11 lock_o high", {31'd0, lock}, 32'd1);
    check_outs("R7 fields with lock");
    do_read(12'hFFC, "R7 readback");

    // R2 R3 frozen window
    do_write(12'hFFC, 4'b1111, 32'h0000_0000);
    do_read(12'hFFC, "R2 no clear");
    for (int i = 0; i < 200; i++) begin
      a = rand_addr();
      do_write(a, 4'($urandom_range(0, 15)), $urandom());
      do_read(rand_addr(), "R3 frozen read");
    end
    check_outs("R3 outputs frozen");
    check("R11 lock stays", {31'd0, lock}, 32'd1);

    // R2 only reset releases
    apply_reset();
    do_read(12'hFFC, "R2 reset unlocks");
    check_outs("R1 after second reset");
    do_write(12'hF00, 4'b1111, 32'hCAFE_F00D);
    do_read(12'hF00, "R9 gp0 writable again");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule